// File: doc/BRIEF.md
# Registered-Read Synchronous FIFO

This block is a single-clock first-in first-out queue built around a storage array that can only be read through a clocked port, as block RAM requires. The producer side is a valid/ready stream (`in_valid`, `in_ready`, `in_data`). The consumer side is a valid/ready stream with first-word-fall-through behaviour (`out_valid`, `out_ready`, `out_data`). One occupancy count, `fill_level`, serves both sides.

The head of the queue sits in the array's read register. That register also serves as the output register, so `out_data` is valid whenever `out_valid` is high. It counts as one storage slot, which means the array itself holds `DEPTH-1` entries.

Back-pressure works as follows:
- A transfer happens on a rising edge where valid and ready are both high.
- The producer may hold `in_valid` for as long as it likes. While `in_ready` is low, nothing is taken.
- The consumer may hold `out_ready` high while the queue is empty. Nothing is taken then either.
- `in_ready` depends on `out_ready` in one case only: a full queue accepts a write in the same cycle as a pop.

A word written into an empty queue reaches the output one cycle later than it would through a queue with an asynchronous read. This is the price of the registered read.

Top module: `rr_sync_fifo`

## Requirements
- R1: After reset, `fill_level` is 0, `out_valid` is 0 and, for `DEPTH` > 0, `in_ready` is 1.
- R2: Words leave on `out_data` in exactly the order in which they were accepted, with no loss and no duplication.
- R3: A word accepted at rising edge k into an empty queue is not yet visible after edge k. It is visible after edge k+1, with `out_valid` high and `out_data` equal to that word.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. A pop at edge k presents the next stored word after edge k, if one exists.
- R5: With at least two words stored, `out_ready` held high yields one word per cycle, with `out_valid` high in every cycle until the queue is empty.
- R6: `fill_level` equals accepted writes minus accepted pops, and stays within 0 to `DEPTH`. `in_ready` is low only when `fill_level` equals `DEPTH` and no pop is taking place.
- R7: A write offered while `in_ready` is low is dropped: the level is unchanged and the word never appears. A pop request while `out_valid` is low has no effect.
- R8: In a full queue, a write and a pop in the same cycle are both accepted. The level stays at `DEPTH` and the order of the words is kept.
- R9: With `DEPTH` = 0, `in_ready`, `out_valid` and `fill_level` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Write word |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Queue can take a word this cycle |
| out_data | output | DATA_W | Head word, valid while out_valid is high |
| out_valid | output | 1 | Head word present |
| out_ready | input | 1 | Consumer takes the head word |
| fill_level | output | LVL_W | Number of stored words, 0 to DEPTH |

## Verification
Each kind of internal fault shows up at the ports within a few cycles:
- A slipped read or write pointer corrupts the order of words. The reference queue flags this on the first pop that follows.
- A stale array count leaves `out_valid` low during back-to-back pops, or lets a fetch from an empty array land in the output register. The bubble-free drain check catches the first case; a data mismatch or a `fill_level` disagreement with the reference count catches the second.
- A fetch issued one cycle early or late shifts the two-edge visibility of the first word. The directed latency check samples exactly that cycle.

// File: rtl/rrq_pkg.sv
package rrq_pkg;
  // words held by the array: the output register takes one slot
  function automatic int mem_depth(int depth);
    return (depth > 1) ? depth - 1 : 1;
  endfunction

  // index width for n entries, at least one bit
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a count ranging 0..n
  function automatic int cnt_w(int n);
    return (n > 0) ? $clog2(n + 1) : 1;
  endfunction
endpackage

// File: rtl/rrq_ram.sv
module rrq_ram #(
  parameter int DATA_W = 8,
  parameter int ENTRIES = 3,
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // clocked read port, read-before-write on an address collision
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rrq_ctrl.sv
module rrq_ctrl #(
  parameter int DEPTH = 4,
  parameter int MEM_D = 3,
  parameter int AW = 2,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic          head_vld,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [LW-1:0] level
);
  localparam int CW = rrq_pkg::cnt_w(MEM_D);
  localparam logic [AW-1:0] LAST = AW'(MEM_D - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [AW-1:0] wp, rp;
  logic [CW-1:0] mcnt;
  logic [LW-1:0] lvl;
  logic          vld;
  logic          push, pop, fetch;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop   = rd_req && vld;
  assign wr_ok = (lvl != FULL) || pop;
  assign push  = wr_req && wr_ok;
  assign fetch = (!vld || pop) && (mcnt != '0);

  assign mem_we    = push;
  assign mem_waddr = wp;
  assign mem_re    = fetch;
  assign mem_raddr = rp;
  assign head_vld  = vld;
  assign level     = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      mcnt <= '0;
      lvl  <= '0;
      vld  <= 1'b0;
    end else begin
      if (push)  wp <= step(wp);
      if (fetch) rp <= step(rp);
      case ({push, fetch})
        2'b10:   mcnt <= mcnt + 1'b1;
        2'b01:   mcnt <= mcnt - 1'b1;
        default: mcnt <= mcnt;
      endcase
      case ({push, pop})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
      if (fetch)    vld <= 1'b1;
      else if (pop) vld <= 1'b0;
    end
  end

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= FULL);
  a_r6_level_balance: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lvl) == 32'(mcnt) + 32'(vld));
  a_r7_empty_no_head: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |-> !vld);
  a_r5_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && mcnt != '0) |=> vld);
endmodule

// File: rtl/rr_sync_fifo.sv
module rr_sync_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 4,
  localparam int LVL_W = rrq_pkg::cnt_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LVL_W-1:0]  fill_level
);
  localparam int MEM_D = rrq_pkg::mem_depth(DEPTH);
  localparam int AW = rrq_pkg::idx_w(MEM_D);

  generate
    if (DEPTH == 0) begin : g_none
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, in_data, in_valid, out_ready};
      assign in_ready   = 1'b0;
      assign out_valid  = 1'b0;
      assign out_data   = '0;
      assign fill_level = '0;
    end else begin : g_queue
      logic          we, re;
      logic [AW-1:0] wa, ra;

      rrq_ctrl #(.DEPTH(DEPTH), .MEM_D(MEM_D), .AW(AW), .LW(LVL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_req(in_valid), .rd_req(out_ready),
        .wr_ok(in_ready), .head_vld(out_valid),
        .mem_we(we), .mem_waddr(wa), .mem_re(re), .mem_raddr(ra),
        .level(fill_level)
      );

      rrq_ram #(.DATA_W(DATA_W), .ENTRIES(MEM_D), .AW(AW)) u_ram (
        .clk(clk), .we(we), .waddr(wa), .wdata(in_data),
        .re(re), .raddr(ra), .rdata(out_data)
      );

      a_r4_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end
  endgenerate
endmodule

// File: tb/tb_rr_sync_fifo.sv
`timescale 1ns/1ps
module tb_rr_sync_fifo;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;
  logic [2:0] fill_level;
  logic in_ready0, out_valid0;
  logic [W-1:0] out_data0;
  logic [0:0] fill_level0;

  int n_run = 0, n_fail = 0;
  int mlvl = 0;
  logic [W-1:0] mq[$];

  always #10 clk = ~clk;

  rr_sync_fifo #(.DATA_W(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .fill_level(fill_level));

  rr_sync_fifo #(.DATA_W(W), .DEPTH(0)) dut0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready0), .out_data(out_data0), .out_valid(out_valid0),
    .out_ready(out_ready), .fill_level(fill_level0));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus, record accepted writes
  task automatic cyc(input logic iv, input logic [W-1:0] d, input logic ordy);
    @(negedge clk);
    in_valid = iv;
    in_data = d;
    out_ready = ordy;
    #1;
    if (in_valid && in_ready) mq.push_back(in_data);
  endtask

  // monitor: compare pops against the reference queue, track level
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      check("R6 level", 32'(fill_level), 32'(mlvl));
      check("R6 in_ready", 32'(in_ready), 32'((mlvl != D) || (out_valid && out_ready)));
      check("R9 depth0", {29'd0, in_ready0, out_valid0, fill_level0}, 32'd0);
      if (out_valid && out_ready) begin
        if (mq.size() == 0) check("R2 pop from empty model", 32'(out_data), 32'hFFFF_FFFF);
        else check("R2 order", 32'(out_data), 32'(mq.pop_front()));
      end
      mlvl = mlvl + int'(in_valid && in_ready) - int'(out_valid && out_ready);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0);
    check("R1 level", 32'(fill_level), 0);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 1);

    // R3: two-edge visibility into an empty queue
    cyc(1, 8'hA1, 0);
    cyc(0, 0, 0);
    check("R3 not after one edge", 32'(out_valid), 0);
    cyc(0, 0, 0);
    check("R3 valid after two edges", 32'(out_valid), 1);
    check("R3 data", 32'(out_data), 32'h A1);

    // R4: hold under back-pressure
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0);
      check("R4 hold valid", 32'(out_valid), 1);
      check("R4 hold data", 32'(out_data), 32'hA1);
    end
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    check("R4 empty after pop", 32'(out_valid), 0);

    // fill, then R7 overflow attempt
    for (int i = 0; i < 4; i++) cyc(1, 8'(8'h10 + i), 0);
    cyc(1, 8'hEE, 0);
    check("R7 full in_ready", 32'(in_ready), 0);
    cyc(0, 0, 0);
    check("R7 level after dropped write", 32'(fill_level), 4);

    // R8: write and pop while full
    cyc(1, 8'h55, 1);
    check("R8 in_ready while full and popping", 32'(in_ready), 1);
    cyc(0, 0, 0);
    check("R8 level stays full", 32'(fill_level), 4);

    // R5: bubble-free drain
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1);
      check("R5 back-to-back valid", 32'(out_valid), 1);
    end
    cyc(0, 0, 1);
    check("R7 pop on empty", 32'(out_valid), 0);
    cyc(0, 0, 0);
    check("R7 level after empty pop", 32'(fill_level), 0);

    // random traffic
    for (int i = 0; i < 400; i++)
      cyc(1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 2) != 0));
    for (int i = 0; i < 12; i++) cyc(0, 0, 1);
    cyc(0, 0, 0);
    check("R2 model drained", 32'(mq.size()), 0);
    check("R6 final level", 32'(fill_level), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule